// File: doc/BRIEF.md
# SPI Command Frame Decoder

This block sits on the device side of a byte-wide SPI link, behind a byte-level slave that has already deserialized the wire traffic. Each frame starts with an opcode byte. The opcode fixes how many address, length and data bytes follow. When the link's CRC7 protection is switched on, one more check byte follows those fields. The decoder gathers the fields and checks that trailer. It then hands a decoded request (opcode, address, length, write data, clockless flag) to the memory side over a valid/ready pair. Last, it returns the two-byte command response: the opcode echoed back, then a status byte.

A small protocol control register lives inside the decoder and drives the CRC7 enable, the CRC16 enable and the log2 packet size for the data path. An internal write aimed at a parameterised internal address loads this register directly. A reset command puts it back to its default value. Dropping chip select returns the decoder to idle at any point in a frame.

Top module: `spi_cmd_decoder`

## Requirements
- R1: Opcodes 0xC1 (DMA write) and 0xC2 (DMA read) take a 3-byte address and a 2-byte length. The fields are sent MSB first and appear on `req_addr_o` and `req_len_o`, with `req_wdata_o` = 0 and `req_clockless_o` = 0.
- R2: Opcodes 0xC7 and 0xC8 (extended DMA write/read) take a 3-byte address and a 3-byte length, both MSB first.
- R3: Opcode 0xC9 (single write) takes a 3-byte address and 4 data bytes, MSB first. Opcode 0xCA (single read) takes a 3-byte address. Both present `req_len_o` = 4, and a read presents wdata 0.
- R4: Opcodes 0xC3 (internal write: 2 address bytes then 4 data bytes) and 0xC4 (internal read: 3 bytes) form a 15-bit address from bits 6:0 of the first byte and all of the second byte. Bit 7 of the first byte drives `req_clockless_o`. The third byte of an internal read is ignored. The length is 4.
- R5: While CRC7 is enabled, one byte follows the fields. It must equal {crc, 1}, where crc is the 7-bit CRC (polynomial x^7+x^3+1, register preset to all ones, MSB first) over the opcode and all field bytes. On a mismatch the status is 0x02 and no request is issued.
- R6: While CRC7 is disabled, no trailer is expected, and the frame completes on its last field byte.
- R7: A good frame produces its request first (when it has one). After the request is accepted, the response follows on `rsp_byte_o`: the opcode byte, then status 0x00.
- R8: An opcode outside the set 0xC1 to 0xCA plus 0xCF gets an echo and status 0x01, with no request. A reset frame whose three bytes are not all 0xFF also gets status 0x01.
- R9: Deasserting `cs_i` abandons any partial frame, pending request or pending response. The next cycle shows neither `req_valid_o` nor `rsp_valid_o`.
- R10: The protocol register resets to CRC7 on, CRC16 off, log2 size 13. A good internal write to address `PROTO_ADDR` loads it from data bits 2 (CRC7), 3 (CRC16) and 6:4 (log2 size minus 8, where values above 5 become 5). That write issues no request.
- R11: Opcode 0xCF with bytes FF FF FF issues no request. It answers 0xCF, 0x00, and once the status byte is taken, it restores the protocol register default.
- R12: While `req_valid_o` is high and `req_ready_i` is low, the request and all its fields stay stable.
- R13: Bytes that arrive while a request or response is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select asserted (active high) |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| req_valid_o | output | 1 | Decoded request valid |
| req_ready_i | input | 1 | Memory side accepts request |
| req_op_o | output | 8 | Request opcode |
| req_addr_o | output | 24 | Request address |
| req_len_o | output | 24 | Request length in bytes |
| req_wdata_o | output | 32 | Write data for single/internal writes |
| req_clockless_o | output | 1 | Clockless internal access |
| rsp_valid_o | output | 1 | Response byte valid |
| rsp_ready_i | input | 1 | Slave takes the response byte |
| rsp_byte_o | output | 8 | Response byte (opcode echo, then status) |
| crc7_en_o | output | 1 | CRC7 enable from the protocol register |
| crc16_en_o | output | 1 | CRC16 enable from the protocol register |
| pkt_log2_o | output | 4 | log2 of data packet size (8 to 13) |

## Verification
After the last byte of a frame, whether a field byte or the CRC trailer, one cycle is spent evaluating the frame. The request becomes valid at the second clock edge. The opcode echo is offered on the edge after the request is accepted, and the status byte on the edge after the echo is taken. Errored, reset and register-write frames skip the request stage. Because these times depend on the handshakes, the scoreboard does not wait a fixed number of cycles. It compares each item at the clock edge where valid and ready are both high, sampling a quarter period before that edge, against a queue filled in frame order. A ready pattern that stalls both handshakes at different rates exercises the hold behaviour. Protocol register outputs are checked at the ports only after the response queue has drained and chip select has dropped, which is after the update is due.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 24;
  localparam int LEN_W      = 24;
  localparam int DATA_W     = 32;
  localparam int INT_ADDR_W = 15;
  localparam int CRC_W      = 7;
  localparam int MAX_FIELDS = 7;
  localparam int BUF_W      = MAX_FIELDS * BYTE_W;
  localparam int CNT_W      = $clog2(MAX_FIELDS + 1);

  localparam logic [CRC_W-1:0]  CRC_POLY = 7'h09;
  localparam logic [CRC_W-1:0]  CRC_SEED = 7'h7F;

  localparam logic [BYTE_W-1:0] ST_OK      = 8'h00;
  localparam logic [BYTE_W-1:0] ST_BAD_CMD = 8'h01;
  localparam logic [BYTE_W-1:0] ST_BAD_CRC = 8'h02;

  typedef enum logic [BYTE_W-1:0] {
    OP_DMA_WR  = 8'hC1,
    OP_DMA_RD  = 8'hC2,
    OP_INT_WR  = 8'hC3,
    OP_INT_RD  = 8'hC4,
    OP_TERM    = 8'hC5,
    OP_RPT     = 8'hC6,
    OP_XDMA_WR = 8'hC7,
    OP_XDMA_RD = 8'hC8,
    OP_SGL_WR  = 8'hC9,
    OP_SGL_RD  = 8'hCA,
    OP_RST     = 8'hCF
  } opcode_e;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic [DATA_W-1:0] wdata;
    logic              clockless;
  } req_t;

  // bytes following the opcode; 0 marks an unknown opcode
  function automatic logic [CNT_W-1:0] field_bytes(logic [BYTE_W-1:0] op);
    case (op)
      OP_DMA_WR, OP_DMA_RD:   return CNT_W'(5);
      OP_XDMA_WR, OP_XDMA_RD: return CNT_W'(6);
      OP_INT_WR:              return CNT_W'(6);
      OP_SGL_WR:              return CNT_W'(7);
      OP_INT_RD, OP_SGL_RD,
      OP_TERM, OP_RPT,
      OP_RST:                 return CNT_W'(3);
      default:                return '0;
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_crc7.sv
module spi_cmd_crc7
  import spi_cmd_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);

  logic [CRC_W-1:0] stage [BYTE_W+1];

  assign stage[0] = crc_i;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    logic fb;
    assign fb = stage[b][CRC_W-1] ^ byte_i[BYTE_W-1-b];
    assign stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  assign crc_o = stage[BYTE_W];

endmodule

// File: rtl/spi_cmd_fields.sv
module spi_cmd_fields
  import spi_cmd_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  input  logic [BUF_W-1:0]  buf_i,
  output req_t              req_o,
  output logic              rst_pattern_ok_o
);

  localparam int IAHI_W = INT_ADDR_W - BYTE_W;

  always_comb begin
    req_o           = '0;
    req_o.op        = op_i;
    case (op_i)
      OP_DMA_WR, OP_DMA_RD: begin
        req_o.addr = buf_i[39:16];
        req_o.len  = LEN_W'(buf_i[15:0]);
      end
      OP_XDMA_WR, OP_XDMA_RD: begin
        req_o.addr = buf_i[47:24];
        req_o.len  = buf_i[23:0];
      end
      OP_SGL_WR: begin
        req_o.addr  = buf_i[55:32];
        req_o.wdata = buf_i[31:0];
        req_o.len   = LEN_W'(4);
      end
      OP_SGL_RD: begin
        req_o.addr = buf_i[23:0];
        req_o.len  = LEN_W'(4);
      end
      OP_INT_WR: begin
        req_o.addr      = ADDR_W'({buf_i[40 +: IAHI_W], buf_i[39:32]});
        req_o.clockless = buf_i[47];
        req_o.wdata     = buf_i[31:0];
        req_o.len       = LEN_W'(4);
      end
      OP_INT_RD: begin
        // third byte is padding
        req_o.addr      = ADDR_W'({buf_i[16 +: IAHI_W], buf_i[15:8]});
        req_o.clockless = buf_i[23];
        req_o.len       = LEN_W'(4);
      end
      default: ;
    endcase
  end

  assign rst_pattern_ok_o = (buf_i[23:0] == 24'hFF_FFFF);

endmodule

// File: rtl/spi_cmd_proto_reg.sv
module spi_cmd_proto_reg
  import spi_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RST_VAL = 8'h54,
  parameter int                LOG_MIN = 8,
  parameter int                LOG_MAX = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              restore_i,
  output logic              crc7_en_o,
  output logic              crc16_en_o,
  output logic [3:0]        pkt_log2_o
);

  localparam logic [2:0] FIELD_MAX = 3'(LOG_MAX - LOG_MIN);

  logic       crc7_q, crc16_q;
  logic [2:0] size_q, size_in;

  assign size_in = (wdata_i[6:4] > FIELD_MAX) ? FIELD_MAX : wdata_i[6:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc7_q  <= RST_VAL[2];
      crc16_q <= RST_VAL[3];
      size_q  <= RST_VAL[6:4];
    end else if (restore_i) begin
      crc7_q  <= RST_VAL[2];
      crc16_q <= RST_VAL[3];
      size_q  <= RST_VAL[6:4];
    end else if (we_i) begin
      crc7_q  <= wdata_i[2];
      crc16_q <= wdata_i[3];
      size_q  <= size_in;
    end
  end

  assign crc7_en_o  = crc7_q;
  assign crc16_en_o = crc16_q;
  assign pkt_log2_o = 4'(size_q) + 4'(LOG_MIN);

  assert_restore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (crc7_en_o == RST_VAL[2]) && (crc16_en_o == RST_VAL[3]) &&
                  (pkt_log2_o == 4'(RST_VAL[6:4]) + 4'(LOG_MIN)));

  assert_pkt_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_log2_o >= 4'(LOG_MIN)) && (pkt_log2_o <= 4'(LOG_MAX)));

  assert_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !restore_i) |=> (crc7_en_o == $past(wdata_i[2])) &&
                              (crc16_en_o == $past(wdata_i[3])));

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter logic [INT_ADDR_W-1:0] PROTO_ADDR = 15'h0024,
  parameter logic [BYTE_W-1:0]     PROTO_RST  = 8'h54
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [BYTE_W-1:0] req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic [DATA_W-1:0] req_wdata_o,
  output logic              req_clockless_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [BYTE_W-1:0] rsp_byte_o,
  output logic              crc7_en_o,
  output logic              crc16_en_o,
  output logic [3:0]        pkt_log2_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_FIELD, S_CRC, S_EVAL, S_ISSUE, S_RSP_OP, S_RSP_ST
  } state_e;

  state_e            state_q;
  logic [BYTE_W-1:0] op_q, status_q;
  logic [CNT_W-1:0]  cnt_q, need_q, need_d;
  logic [BUF_W-1:0]  buf_q;
  logic [CRC_W-1:0]  crc_q, crc_sel, crc_next;
  logic              crc_bad_q;
  logic [BYTE_W-1:0] crc_expect;

  req_t              req;
  logic              rst_pattern_ok;
  logic              proto_we, restore, is_proto_wr;

  assign crc_sel    = (state_q == S_IDLE) ? CRC_SEED : crc_q;
  assign crc_expect = {crc_q, 1'b1};
  assign need_d     = field_bytes(rx_byte_i);

  spi_cmd_crc7 u_crc7 (
    .crc_i  (crc_sel),
    .byte_i (rx_byte_i),
    .crc_o  (crc_next)
  );

  spi_cmd_fields u_fields (
    .op_i             (op_q),
    .buf_i            (buf_q),
    .req_o            (req),
    .rst_pattern_ok_o (rst_pattern_ok)
  );

  assign is_proto_wr = (op_q == OP_INT_WR) && (req.addr[INT_ADDR_W-1:0] == PROTO_ADDR);
  assign proto_we    = cs_i && (state_q == S_EVAL) && !crc_bad_q && is_proto_wr;
  assign restore     = cs_i && (state_q == S_RSP_ST) && rsp_ready_i &&
                       (op_q == OP_RST) && (status_q == ST_OK);

  spi_cmd_proto_reg #(
    .RST_VAL (PROTO_RST)
  ) u_proto (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (proto_we),
    .wdata_i    (req.wdata[BYTE_W-1:0]),
    .restore_i  (restore),
    .crc7_en_o  (crc7_en_o),
    .crc16_en_o (crc16_en_o),
    .pkt_log2_o (pkt_log2_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      op_q      <= '0;
      status_q  <= ST_OK;
      cnt_q     <= '0;
      need_q    <= '0;
      buf_q     <= '0;
      crc_q     <= CRC_SEED;
      crc_bad_q <= 1'b0;
    end else if (!cs_i) begin
      state_q <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: if (rx_valid_i) begin
          op_q      <= rx_byte_i;
          crc_q     <= crc_next;
          buf_q     <= '0;
          cnt_q     <= '0;
          need_q    <= need_d;
          crc_bad_q <= 1'b0;
          if (need_d == '0) begin
            status_q <= ST_BAD_CMD;
            state_q  <= S_RSP_OP;
          end else begin
            state_q  <= S_FIELD;
          end
        end
        S_FIELD: if (rx_valid_i) begin
          buf_q <= {buf_q[BUF_W-BYTE_W-1:0], rx_byte_i};
          crc_q <= crc_next;
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q + CNT_W'(1) == need_q)
            state_q <= crc7_en_o ? S_CRC : S_EVAL;
        end
        S_CRC: if (rx_valid_i) begin
          crc_bad_q <= (rx_byte_i != crc_expect);
          state_q   <= S_EVAL;
        end
        S_EVAL: begin
          if (crc_bad_q) begin
            status_q <= ST_BAD_CRC;
            state_q  <= S_RSP_OP;
          end else if (op_q == OP_RST) begin
            status_q <= rst_pattern_ok ? ST_OK : ST_BAD_CMD;
            state_q  <= S_RSP_OP;
          end else if (is_proto_wr) begin
            status_q <= ST_OK;
            state_q  <= S_RSP_OP;
          end else begin
            status_q <= ST_OK;
            state_q  <= S_ISSUE;
          end
        end
        S_ISSUE:  if (req_ready_i) state_q <= S_RSP_OP;
        S_RSP_OP: if (rsp_ready_i) state_q <= S_RSP_ST;
        S_RSP_ST: if (rsp_ready_i) state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign req_valid_o     = (state_q == S_ISSUE);
  assign req_op_o        = req.op;
  assign req_addr_o      = req.addr;
  assign req_len_o       = req.len;
  assign req_wdata_o     = req.wdata;
  assign req_clockless_o = req.clockless;

  assign rsp_valid_o = (state_q == S_RSP_OP) || (state_q == S_RSP_ST);
  assign rsp_byte_o  = (state_q == S_RSP_ST) ? status_q : op_q;

  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni || !cs_i)
    (req_valid_o && !req_ready_i) |=> req_valid_o && $stable(req_op_o) &&
      $stable(req_addr_o) && $stable(req_len_o) && $stable(req_wdata_o) &&
      $stable(req_clockless_o));

  assert_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !req_valid_o && !rsp_valid_o);

  assert_known_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (field_bytes(req_op_o) != '0) && (req_op_o != OP_RST));

  assert_status_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !cs_i)
    (state_q == S_RSP_OP && rsp_ready_i) |=> rsp_valid_o && (rsp_byte_o == status_q));

  assert_crc_fail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !cs_i)
    (state_q == S_CRC && rx_valid_i && rx_byte_i != crc_expect) |=> ##1
      (!req_valid_o && rsp_valid_o && status_q == ST_BAD_CRC));

endmodule

// File: tb/spi_cmd_decoder_tb.sv
module spi_cmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        req_valid, req_ready = 1'b0;
  logic [7:0]  req_op;
  logic [23:0] req_addr, req_len;
  logic [31:0] req_wdata;
  logic        req_cl;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [7:0]  rsp_byte;
  logic        crc7_en, crc16_en;
  logic [3:0]  pkt_log2;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  logic [96:0] exp_req [$];
  logic [7:0]  exp_rsp [$];
  logic [7:0]  fr [0:9];

  always #10 clk = ~clk;

  spi_cmd_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_op_o(req_op),
    .req_addr_o(req_addr), .req_len_o(req_len), .req_wdata_o(req_wdata),
    .req_clockless_o(req_cl), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_byte_o(rsp_byte), .crc7_en_o(crc7_en), .crc16_en_o(crc16_en),
    .pkt_log2_o(pkt_log2)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic [7:0] b);
    logic [6:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic f = r[6] ^ b[i];
      r = {r[5:0], 1'b0};
      if (f) r = r ^ 7'h09;
    end
    return r;
  endfunction

  // ready patterns stall both handshakes at different rates
  initial forever begin
    @(negedge clk);
    cyc++;
    req_ready = (cyc % 3) != 0;
    rsp_ready = (cyc % 5) != 0;
  end

  // scoreboard monitor, a quarter period before each rising edge
  initial forever begin
    @(negedge clk);
    #5;
    if (rst_n && req_valid && req_ready) begin
      if (exp_req.size() == 0) check("R7 unexpected request", {req_op, req_addr}, 0);
      else check("R1-R4 request", {req_op, req_addr, req_len, req_wdata, req_cl},
                 exp_req.pop_front());
    end
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_rsp.size() == 0) check("R7 unexpected response", rsp_byte, 8'hxx);
      else check("R7 response byte", rsp_byte, exp_rsp.pop_front());
    end
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // crc_mode: 0 none, 1 good trailer, 2 corrupted trailer
  task automatic send_frame(input int n, input int crc_mode);
    logic [6:0] c = 7'h7F;
    cs = 1'b1;
    for (int i = 0; i < n; i++) begin
      send_byte(fr[i]);
      c = crc7_step(c, fr[i]);
    end
    if (crc_mode == 1) send_byte({c, 1'b1});
    if (crc_mode == 2) send_byte({c, 1'b1} ^ 8'h02);
  endtask

  task automatic end_frame();
    int t = 0;
    while ((exp_req.size() != 0 || exp_rsp.size() != 0) && t < 300) begin
      @(negedge clk);
      t++;
    end
    if (t >= 300) check("R7 drain timeout", 0, 1);
    repeat (2) @(negedge clk);
    cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic push_req(input logic [7:0] op, input logic [23:0] a, input logic [23:0] l,
                          input logic [31:0] d, input logic cl);
    exp_req.push_back({op, a, l, d, cl});
  endtask

  task automatic push_rsp(input logic [7:0] op, input logic [7:0] st);
    exp_rsp.push_back(op);
    exp_rsp.push_back(st);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset req_valid", req_valid, 0);
    check("R10 reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 default crc7_en", crc7_en, 1);
    check("R10 default crc16_en", crc16_en, 0);
    check("R10 default pkt_log2", pkt_log2, 13);

    // R1, R5: DMA read with good CRC7
    fr[0]=8'hC2; fr[1]=8'h12; fr[2]=8'h34; fr[3]=8'h56; fr[4]=8'h02; fr[5]=8'h00;
    push_req(8'hC2, 24'h123456, 24'h000200, 0, 0); push_rsp(8'hC2, 8'h00);
    send_frame(6, 1); end_frame();

    // R5: corrupted trailer on a single read
    fr[0]=8'hCA; fr[1]=8'h00; fr[2]=8'h10; fr[3]=8'h00;
    push_rsp(8'hCA, 8'h02);
    send_frame(4, 2); end_frame();

    // R8: unknown opcode
    fr[0]=8'hB5;
    push_rsp(8'hB5, 8'h01);
    send_frame(1, 0); end_frame();

    // R10: protocol write, CRC7 off, CRC16 on, size field 7 clamps to 5
    fr[0]=8'hC3; fr[1]=8'h00; fr[2]=8'h24; fr[3]=8'h00; fr[4]=8'h00; fr[5]=8'h00; fr[6]=8'h78;
    push_rsp(8'hC3, 8'h00);
    send_frame(7, 1); end_frame();
    check("R10 crc7_en after write", crc7_en, 0);
    check("R10 crc16_en after write", crc16_en, 1);
    check("R10 pkt_log2 clamp", pkt_log2, 13);

    // R2, R6: extended DMA write without trailer
    fr[0]=8'hC7; fr[1]=8'hAB; fr[2]=8'hCD; fr[3]=8'hEF; fr[4]=8'h01; fr[5]=8'h23; fr[6]=8'h45;
    push_req(8'hC7, 24'hABCDEF, 24'h012345, 0, 0); push_rsp(8'hC7, 8'h00);
    send_frame(7, 0); end_frame();

    // R3, R13: single write, extra byte during the pending request is ignored
    fr[0]=8'hC9; fr[1]=8'h00; fr[2]=8'hF0; fr[3]=8'h0D;
    fr[4]=8'hDE; fr[5]=8'hAD; fr[6]=8'hBE; fr[7]=8'hEF;
    push_req(8'hC9, 24'h00F00D, 24'd4, 32'hDEADBEEF, 0); push_rsp(8'hC9, 8'h00);
    send_frame(8, 0); send_byte(8'hC1); end_frame();

    // R3: single read
    fr[0]=8'hCA; fr[1]=8'h40; fr[2]=8'h00; fr[3]=8'h08;
    push_req(8'hCA, 24'h400008, 24'd4, 0, 0); push_rsp(8'hCA, 8'h00);
    send_frame(4, 0); end_frame();

    // R4: clockless internal read, pad byte ignored
    fr[0]=8'hC4; fr[1]=8'h85; fr[2]=8'h12; fr[3]=8'h77;
    push_req(8'hC4, 24'h000512, 24'd4, 0, 1); push_rsp(8'hC4, 8'h00);
    send_frame(4, 0); end_frame();

    // R4: internal write to an ordinary address
    fr[0]=8'hC3; fr[1]=8'h01; fr[2]=8'h34;
    fr[3]=8'h11; fr[4]=8'h22; fr[5]=8'h33; fr[6]=8'h44;
    push_req(8'hC3, 24'h000134, 24'd4, 32'h11223344, 0); push_rsp(8'hC3, 8'h00);
    send_frame(7, 0); end_frame();

    // R1: terminate passes through with zero length
    fr[0]=8'hC5; fr[1]=8'h00; fr[2]=8'h00; fr[3]=8'h00;
    push_req(8'hC5, 0, 0, 0, 0); push_rsp(8'hC5, 8'h00);
    send_frame(4, 0); end_frame();

    // R10: CRC7 back on, size field 1
    fr[0]=8'hC3; fr[1]=8'h00; fr[2]=8'h24; fr[3]=8'h00; fr[4]=8'h00; fr[5]=8'h00; fr[6]=8'h14;
    push_rsp(8'hC3, 8'h00);
    send_frame(7, 0); end_frame();
    check("R10 crc7_en on", crc7_en, 1);
    check("R10 crc16_en off", crc16_en, 0);
    check("R10 pkt_log2 9", pkt_log2, 9);

    // R9: partial frame abandoned by chip select
    fr[0]=8'hC9; fr[1]=8'h00; fr[2]=8'h11;
    send_frame(3, 0);
    cs = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 no request after abort", req_valid, 0);
    check("R9 no response after abort", rsp_valid, 0);
    fr[0]=8'hC8; fr[1]=8'h00; fr[2]=8'h01; fr[3]=8'h02; fr[4]=8'h00; fr[5]=8'h10; fr[6]=8'h00;
    push_req(8'hC8, 24'h000102, 24'h001000, 0, 0); push_rsp(8'hC8, 8'h00);
    send_frame(7, 1); end_frame();

    // R8: reset frame with bad pattern leaves register alone
    fr[0]=8'hCF; fr[1]=8'hFF; fr[2]=8'h00; fr[3]=8'hFF;
    push_rsp(8'hCF, 8'h01);
    send_frame(4, 1); end_frame();
    check("R8 bad reset keeps pkt_log2", pkt_log2, 9);

    // R11: reset command restores default
    fr[0]=8'hCF; fr[1]=8'hFF; fr[2]=8'hFF; fr[3]=8'hFF;
    push_rsp(8'hCF, 8'h00);
    send_frame(4, 1); end_frame();
    check("R11 restored pkt_log2", pkt_log2, 13);
    check("R11 restored crc7_en", crc7_en, 1);
    check("R11 restored crc16_en", crc16_en, 0);

    // R6: with CRC7 on again, DMA write needs its trailer
    fr[0]=8'hC1; fr[1]=8'h00; fr[2]=8'h00; fr[3]=8'h40; fr[4]=8'h00; fr[5]=8'h08;
    push_req(8'hC1, 24'h000040, 24'h000008, 0, 0); push_rsp(8'hC1, 8'h00);
    send_frame(6, 1); end_frame();

    check("R7 scoreboard empty", exp_req.size() + exp_rsp.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule